// File: doc/BRIEF.md
# Motor Protection and Brake Supervisor

This block turns the protection and stop inputs of a three-phase bridge controller into one decision: a single fault flag, a drive mode code (run, coast or brake), a mask that shuts off only the high-side gates, and a per-phase permit that the gate sequencer must hold before it turns a high side on. Comparators, thresholds and drivers are outside the block. Each one reaches it as a one-bit digital flag.

Each fault source has its own response. An invalid Hall code and over-temperature force coast. Supply undervoltage and a stop request apply a brake-or-coast choice that is captured when the event occurs. A short of a motor lead to ground is held in a latch that disables the high sides only. The latch is released by the next commutation or by a stop request. The stop input passes through a synchronizer inside the block, and the block detects its rising edge there.

Top module: `motor_guard`

## Requirements
- R1: A Hall code of 000 or 111 raises fault_o and forces mode_o to coast (01) with hs_permit_o all zero, even when brake_req is high.
- R2: over_temp high raises fault_o and forces coast (01) whatever brake_pick and brake_req hold.
- R3: A rising edge of the synchronized stop_req, or a rising edge of supply_low, captures brake_pick. The captured value then holds until the next such edge, and later changes of brake_pick have no effect until then.
- R4: While the synchronized stop_req is high, mode_o follows the captured choice: brake (10) for 1, coast (01) for 0. This overrides brake_req. stop_req alone does not raise fault_o.
- R5: With no fault and stop_req low, brake_req high gives brake (10) with hs_permit_o all zero and fault_o low.
- R6: supply_low high raises fault_o and applies the captured choice (brake 10 or coast 01).
- R7: If a phase's high side was on in the previous cycle (hs_sel and hs_permit_o both high) and its hs_vds_hi bit is high, a short is latched. The latch raises fault_o and hs_mask_o, clears every hs_permit_o bit and leaves mode_o at run (00). A hs_vds_hi bit on a phase whose high side is off has no effect.
- R8: A one-cycle commutate strobe clears the latched short. The fault is gone one cycle after the strobe.
- R9: Without a commutation strobe, the latched short persists. Only a synchronized stop_req high level clears it, as it does for a stalled motor.
- R10: In run mode with no latched short, hs_permit_o[i] is the inverse of boot_busy[i]. A busy phase blocks only its own permit.
- R11: With no fault and no stop or brake request, mode_o is run (00), fault_o is low and hs_mask_o is low. These values also hold straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Asynchronous stop request, synchronized inside the block |
| brake_req | input | 1 | Dynamic brake request |
| brake_pick | input | 1 | Brake (1) or coast (0) choice, captured on a trigger event |
| hall | input | 3 | Hall sensor code |
| supply_low | input | 1 | Gate supply undervoltage flag |
| over_temp | input | 1 | Over-temperature flag |
| hs_sel | input | 3 | High sides the commutation logic wants on |
| hs_vds_hi | input | 3 | Per-phase high-side drain-source overvoltage flag |
| commutate | input | 1 | One-cycle strobe at the start of each commutation |
| boot_busy | input | 3 | Per-phase bootstrap charging still above threshold |
| fault_o | output | 1 | Combined fault flag |
| mode_o | output | 2 | Drive mode: 00 run, 01 coast, 10 brake |
| hs_mask_o | output | 1 | High to disable all high sides only |
| hs_permit_o | output | 3 | Per-phase high-side turn-on permit |

## Verification
The bench first drives the arbiter with a valid Hall code and then with 000 and 111. It repeats the stop and undervoltage events under each brake_pick value and changes brake_pick after each event, which separates a value captured at the edge from a live follow of the pin. Competing requests are stacked to pin down the priority order: stop over brake, and over-temperature over both.

The short latch is set from a drain-source flag on a phase that is on, and the same flag is also raised on a phase that is off. This separates real detection from a flag that is never qualified. The latch is then cleared by a commutation strobe, by a stop level, and by neither, which covers the stalled-motor case.

// File: rtl/motor_guard_pkg.sv
package motor_guard_pkg;

  typedef enum logic [1:0] {
    DRV_RUN   = 2'b00,
    DRV_COAST = 2'b01,
    DRV_BRAKE = 2'b10
  } drv_mode_t;

  // Codes with all three sensors equal cannot occur with 120-degree spacing
  function automatic logic hall_code_bad(input logic [2:0] code);
    return (code == 3'b000) || (code == 3'b111);
  endfunction

  // Mode applied during a stop or undervoltage event
  function automatic drv_mode_t event_mode(input logic pick);
    return pick ? DRV_BRAKE : DRV_COAST;
  endfunction

endpackage

// File: rtl/mg_edge_sync.sv
module mg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], din};
  end

  assign level = chain_q[LAST-1];
  assign rise  = chain_q[LAST-1] & ~chain_q[LAST];

  // R3: a rise lasts a single cycle
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/mg_short_latch.sv
module mg_short_latch #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hs_sel,
  input  logic [NPH-1:0] hs_permit,
  input  logic [NPH-1:0] hs_vds_hi,
  input  logic           commutate,
  input  logic           stop_level,
  output logic           short_flag
);
  logic [NPH-1:0] hs_on_q;
  logic           short_seen;
  logic           short_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_on_q <= '0;
    else        hs_on_q <= hs_sel & hs_permit;
  end

  assign short_seen = |(hs_on_q & hs_vds_hi);
  assign short_clr  = commutate | stop_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          short_flag <= 1'b0;
    else if (short_clr)  short_flag <= 1'b0;
    else if (short_seen) short_flag <= 1'b1;
  end

  assert_short_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (short_seen && !short_clr) |=> short_flag);
  assert_commut_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commutate |=> !short_flag);
  assert_short_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flag && !short_clr) |=> short_flag);
endmodule

// File: rtl/mg_mode_arbiter.sv
module mg_mode_arbiter
  import motor_guard_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     hall,
  input  logic           over_temp,
  input  logic           supply_low,
  input  logic           stop_level,
  input  logic           stop_rise,
  input  logic           brake_req,
  input  logic           brake_pick,
  input  logic           short_flag,
  input  logic [NPH-1:0] boot_busy,
  output logic           fault,
  output drv_mode_t      mode,
  output logic [NPH-1:0] hs_permit
);
  logic uv_q;
  logic pick_q;
  logic hall_err;
  logic uv_rise;
  logic trig;
  logic pick_now;

  assign hall_err = hall_code_bad(hall);
  assign uv_rise  = supply_low & ~uv_q;
  assign trig     = uv_rise | stop_rise;
  assign pick_now = trig ? brake_pick : pick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q   <= 1'b0;
      pick_q <= 1'b0;
    end else begin
      uv_q <= supply_low;
      if (trig) pick_q <= brake_pick;
    end
  end

  always_comb begin
    if (hall_err || over_temp)        mode = DRV_COAST;
    else if (supply_low || stop_level) mode = event_mode(pick_now);
    else if (brake_req)               mode = DRV_BRAKE;
    else                              mode = DRV_RUN;
  end

  assign fault = hall_err | over_temp | supply_low | short_flag;

  for (genvar p = 0; p < NPH; p++) begin : g_permit
    assign hs_permit[p] = (mode == DRV_RUN) & ~short_flag & ~boot_busy[p];
  end

  assert_hall_coast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hall_err |-> (mode == DRV_COAST && fault && hs_permit == '0));
  assert_ot_coast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |-> (mode == DRV_COAST && fault));
  assert_pick_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pick_q == $past(brake_pick));
  assert_pick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(pick_q));
  assert_boot_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_permit & boot_busy) == '0);
  assert_run_only_permit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DRV_RUN) |-> hs_permit == '0);
endmodule

// File: rtl/motor_guard.sv
module motor_guard
  import motor_guard_pkg::*;
#(
  parameter int NPH         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_req,
  input  logic           brake_req,
  input  logic           brake_pick,
  input  logic [2:0]     hall,
  input  logic           supply_low,
  input  logic           over_temp,
  input  logic [NPH-1:0] hs_sel,
  input  logic [NPH-1:0] hs_vds_hi,
  input  logic           commutate,
  input  logic [NPH-1:0] boot_busy,
  output logic           fault_o,
  output logic [1:0]     mode_o,
  output logic           hs_mask_o,
  output logic [NPH-1:0] hs_permit_o
);
  logic      stop_level;
  logic      stop_rise;
  logic      short_flag;
  drv_mode_t mode;

  mg_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (stop_req),
    .level (stop_level),
    .rise  (stop_rise)
  );

  mg_short_latch #(.NPH(NPH)) u_short (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_sel     (hs_sel),
    .hs_permit  (hs_permit_o),
    .hs_vds_hi  (hs_vds_hi),
    .commutate  (commutate),
    .stop_level (stop_level),
    .short_flag (short_flag)
  );

  mg_mode_arbiter #(.NPH(NPH)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .hall       (hall),
    .over_temp  (over_temp),
    .supply_low (supply_low),
    .stop_level (stop_level),
    .stop_rise  (stop_rise),
    .brake_req  (brake_req),
    .brake_pick (brake_pick),
    .short_flag (short_flag),
    .boot_busy  (boot_busy),
    .fault      (fault_o),
    .mode       (mode),
    .hs_permit  (hs_permit_o)
  );

  assign mode_o    = mode;
  assign hs_mask_o = short_flag;

  // R4: the stop level never selects run
  assert_stop_no_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_level |-> mode != DRV_RUN);
  // R7: a latched short keeps the high sides masked
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mask_o |-> (hs_permit_o == '0 && fault_o));
endmodule

// File: tb/motor_guard_tb.sv
module motor_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0, brake_req = 1'b0, brake_pick = 1'b0;
  logic [2:0] hall = 3'b101;
  logic       supply_low = 1'b0, over_temp = 1'b0, commutate = 1'b0;
  logic [2:0] hs_sel = 3'b000, hs_vds_hi = 3'b000, boot_busy = 3'b000;
  logic       fault_o, hs_mask_o;
  logic [1:0] mode_o;
  logic [2:0] hs_permit_o;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [1:0] RUN = 2'b00, COAST = 2'b01, BRK = 2'b10;

  always #10 clk = ~clk;

  motor_guard u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .brake_req(brake_req),
    .brake_pick(brake_pick), .hall(hall), .supply_low(supply_low),
    .over_temp(over_temp), .hs_sel(hs_sel), .hs_vds_hi(hs_vds_hi),
    .commutate(commutate), .boot_busy(boot_busy), .fault_o(fault_o),
    .mode_o(mode_o), .hs_mask_o(hs_mask_o), .hs_permit_o(hs_permit_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_all(input string tag, input logic [1:0] m, input logic f,
                            input logic k, input logic [2:0] p);
    checks++;
    if (mode_o !== m || fault_o !== f || hs_mask_o !== k || hs_permit_o !== p) begin
      fails++;
      $display("FAIL %s: mode/fault/mask/permit = %b/%b/%b/%b expected %b/%b/%b/%b",
               tag, mode_o, fault_o, hs_mask_o, hs_permit_o, m, f, k, p);
    end
  endtask

  task automatic t_reset_state;
    tick(1);
    expect_all("R11 reset state", RUN, 0, 0, 3'b111);
  endtask

  task automatic t_boot_busy;
    boot_busy = 3'b010; tick(1);
    expect_all("R10 busy phase 1", RUN, 0, 0, 3'b101);
    boot_busy = 3'b101; tick(1);
    expect_all("R10 busy phases 0,2", RUN, 0, 0, 3'b010);
    boot_busy = 3'b000; tick(1);
  endtask

  task automatic t_hall_bad;
    hall = 3'b000; tick(1);
    expect_all("R1 hall 000", COAST, 1, 0, 3'b000);
    hall = 3'b111; brake_req = 1; tick(1);
    expect_all("R1 hall 111 with brake_req", COAST, 1, 0, 3'b000);
    brake_req = 0; hall = 3'b011; tick(1);
    expect_all("R11 valid hall again", RUN, 0, 0, 3'b111);
  endtask

  task automatic t_brake_req;
    brake_req = 1; tick(1);
    expect_all("R5 brake request", BRK, 0, 0, 3'b000);
    brake_req = 0; tick(1);
  endtask

  task automatic t_stop;
    brake_pick = 1; stop_req = 1; tick(4);
    expect_all("R4 stop with pick 1", BRK, 0, 0, 3'b000);
    brake_pick = 0; tick(2);
    expect_all("R3 pick change ignored while stopped", BRK, 0, 0, 3'b000);
    stop_req = 0; tick(4);
    expect_all("R11 stop released", RUN, 0, 0, 3'b111);
    stop_req = 1; brake_req = 1; tick(4);
    expect_all("R4 stop pick 0 overrides brake_req", COAST, 0, 0, 3'b000);
    stop_req = 0; brake_req = 0; tick(4);
  endtask

  task automatic t_undervoltage;
    brake_pick = 1; supply_low = 1; tick(1);
    expect_all("R6 undervoltage pick 1", BRK, 1, 0, 3'b000);
    brake_pick = 0; tick(2);
    expect_all("R3 pick held during undervoltage", BRK, 1, 0, 3'b000);
    supply_low = 0; tick(1);
    supply_low = 1; tick(1);
    expect_all("R6 undervoltage pick 0", COAST, 1, 0, 3'b000);
    supply_low = 0; tick(1);
  endtask

  task automatic t_over_temp;
    brake_pick = 1; brake_req = 1; over_temp = 1; tick(1);
    expect_all("R2 over-temp beats brake", COAST, 1, 0, 3'b000);
    over_temp = 0; brake_req = 0; brake_pick = 0; tick(1);
    expect_all("R11 after over-temp", RUN, 0, 0, 3'b111);
  endtask

  task automatic make_short;
    hs_sel = 3'b001; tick(1);
    hs_vds_hi = 3'b001; tick(1);
    hs_vds_hi = 3'b000; hs_sel = 3'b000;
  endtask

  task automatic t_short;
    hs_sel = 3'b000; hs_vds_hi = 3'b111; tick(2);
    expect_all("R7 vds flag with high sides off", RUN, 0, 0, 3'b111);
    hs_vds_hi = 3'b000;
    make_short;
    expect_all("R7 short latched", RUN, 1, 1, 3'b000);
    tick(6);
    expect_all("R9 short persists with no commutation", RUN, 1, 1, 3'b000);
    commutate = 1; tick(1);
    commutate = 0;
    expect_all("R8 commutation clears short", RUN, 0, 0, 3'b111);
    make_short;
    expect_all("R7 short latched again", RUN, 1, 1, 3'b000);
    stop_req = 1; tick(4);
    stop_req = 0; tick(4);
    expect_all("R9 stop level clears short", RUN, 0, 0, 3'b111);
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    t_reset_state;
    t_boot_busy;
    t_hall_bad;
    t_brake_req;
    t_stop;
    t_undervoltage;
    t_over_temp;
    t_short;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule